// File: doc/BRIEF.md
# Serial Configuration Sequencer

This block loads a bitstream into a target device through a slave-serial configuration port. On a start request it runs the target's reset handshake on the program pin and the init status line. It then takes configuration bits one at a time from a valid/ready stream and clocks each bit onto the serial clock and data pins. When the stream is exhausted it waits for the target's done line.

Each of the three waits is a polled handshake. The block samples the status line once on entering the wait and again every tick period. It abandons the wait after a fixed number of unsuccessful samples. While the sequence runs, the block holds a busy flag. When it ends, it leaves a two-bit result code that stays valid until the next start. Parameters set the pin timing, the tick period, the number of polls, the depth of the input synchronizers and the active level of the program pin.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset and whenever `busy` is low, `cfg_prog` is at its inactive level, `cfg_clk` and `cfg_din` are both 1, `bit_ready` is 0, and after reset `result` is 0.
- R2: A `start` seen while idle raises `busy` and drives `cfg_prog` active on the next clock edge, and clears `result` to 0 (success). A `start` seen while `busy` is high has no effect on the running sequence.
- R3: While `cfg_prog` is active, the synchronized `cfg_init` is sampled on the first cycle of the phase and then every `TICK_DIV` cycles. If the `POLL_LIMIT`-th sample still finds it high, the sequence ends with `busy` low and `result` = 1.
- R4: Once `cfg_init` has been seen low, `cfg_prog` returns to inactive and the block polls for `cfg_init` high in the same way. On timeout it ends with `result` = 2.
- R5: `bit_ready` is high only while the block is waiting for the next bit. A bit is taken on a clock edge where `bit_valid` and `bit_ready` are both high, and `bit_ready` is low on the following cycle. `bit_last` = 1 on the taken bit marks it as the final one.
- R6: Each taken bit is emitted as four steps of `STEP_DIV` cycles each, with {clk,din} set to {0,1}, {0,bit}, {1,bit} and then {1,1}. The clock is therefore low for exactly 2*`STEP_DIV` cycles per bit, and data is stable across its rising edge.
- R7: Bits appear on `cfg_din` in the order they are taken from the stream, one rising `cfg_clk` edge per bit.
- R8: After the final bit, the block polls the synchronized `cfg_done` in the same way. If `cfg_done` is seen high, the sequence ends with `result` = 0. On timeout it ends with `result` = 3.
- R9: With `PROG_ACTIVE_HIGH` = 0, the active level of `cfg_prog` is 0. With `PROG_ACTIVE_HIGH` = 1 it is 1, and the sequencing is otherwise identical.
- R10: `result` is non-zero only while `busy` is low, and it keeps its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run a configuration sequence |
| busy | output | 1 | Sequence in progress |
| result | output | 2 | 0 success, 1 init-low timeout, 2 init-high timeout, 3 done timeout |
| bit_valid | input | 1 | A configuration bit is offered |
| bit_data | input | 1 | Offered bit value |
| bit_last | input | 1 | Offered bit is the final one |
| bit_ready | output | 1 | Block is ready to take a bit |
| cfg_prog | output | 1 | Program/reset pin to the target |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init | input | 1 | Target init status (asynchronous) |
| cfg_done | input | 1 | Target done status (asynchronous) |

## Verification
The properties assume that `start` is a clean synchronous pulse and that the bit source sets `bit_last` on exactly one bit per sequence. They also assume the status lines are free to change at any time, so nothing is claimed about their timing. The stimulus keeps to this. The bench drives all inputs on the falling clock edge. It models the target as a responder that pulls init low while the program pin is active and releases it a few cycles later. That responder raises done only after it has counted every expected rising clock edge. Randomized bit gaps and stream lengths vary the handshake without ever producing a second final bit. Stuck-line modes hold one status line so that each timeout is reached deliberately.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROG,
    PH_INITWAIT,
    PH_FETCH,
    PH_SHIFT,
    PH_DONEWAIT
  } phase_t;

  localparam logic [1:0] RES_OK           = 2'd0;
  localparam logic [1:0] RES_INIT_LOW_TO  = 2'd1;
  localparam logic [1:0] RES_INIT_HIGH_TO = 2'd2;
  localparam logic [1:0] RES_DONE_TO      = 2'd3;

  // pin levels {clk, din} for one of the four steps of a bit
  function automatic logic [1:0] step_pins(input logic [1:0] step, input logic b);
    case (step)
      2'd0:    step_pins = {1'b0, 1'b1};
      2'd1:    step_pins = {1'b0, b};
      2'd2:    step_pins = {1'b1, b};
      default: step_pins = {1'b1, 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgl_poll_timer.sv
module cfgl_poll_timer #(
  parameter int TICK_DIV   = 125000,
  parameter int POLL_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic poll,
  output logic last
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [TW-1:0] tick_cnt;
  logic [PW-1:0] poll_idx;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tick_cnt <= '0;
    end else if (tick_cnt == TW'(TICK_DIV - 1)) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      poll_idx <= '0;
    end else if (run && poll && !last) begin
      poll_idx <= poll_idx + 1'b1;
    end
  end

  assign poll = (tick_cnt == '0);
  assign last = (poll_idx == PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/cfgl_bit_shifter.sv
module cfgl_bit_shifter
  import cfgl_pkg::*;
#(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic bit_in,
  output logic pin_clk,
  output logic pin_din,
  output logic active,
  output logic finish
);
  localparam int SW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  logic [SW-1:0] cnt;
  logic [1:0]    step;
  logic          bit_q;
  logic          step_end;

  assign step_end = (cnt == SW'(STEP_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      step    <= 2'd0;
      bit_q   <= 1'b0;
      pin_clk <= 1'b1;
      pin_din <= 1'b1;
    end else if (load && !active) begin
      active             <= 1'b1;
      cnt                <= '0;
      step               <= 2'd0;
      bit_q              <= bit_in;
      {pin_clk, pin_din} <= step_pins(2'd0, bit_in);
    end else if (active) begin
      if (step_end) begin
        cnt <= '0;
        if (step == 2'd3) begin
          active <= 1'b0;
        end else begin
          step               <= step + 2'd1;
          {pin_clk, pin_din} <= step_pins(step + 2'd1, bit_q);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign finish = active && (step == 2'd3) && step_end;
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int PROG_ACTIVE_HIGH = 0,
  parameter int STEP_DIV         = 4,
  parameter int TICK_DIV         = 125000,
  parameter int POLL_LIMIT       = 5,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       busy,
  output logic [1:0] result,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       bit_last,
  output logic       bit_ready,
  output logic       cfg_prog,
  output logic       cfg_clk,
  output logic       cfg_din,
  input  logic       cfg_init,
  input  logic       cfg_done
);
  localparam logic PROG_ON  = (PROG_ACTIVE_HIGH != 0);
  localparam logic PROG_OFF = !PROG_ON;

  phase_t     ph, ph_nxt;
  logic [1:0] res_nxt;
  logic       init_s, done_s;
  logic       poll, last_poll, in_wait, restart;
  logic       accept, last_q;
  logic       sh_active, sh_finish;

  cfgl_sync #(.STAGES(SYNC_STAGES)) u_sync_init (
    .clk(clk), .rst(rst), .d(cfg_init), .q(init_s)
  );

  cfgl_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk), .rst(rst), .d(cfg_done), .q(done_s)
  );

  assign in_wait = (ph == PH_PROG) || (ph == PH_INITWAIT) || (ph == PH_DONEWAIT);
  assign restart = (ph_nxt != ph);

  cfgl_poll_timer #(.TICK_DIV(TICK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .run(in_wait),
    .poll(poll), .last(last_poll)
  );

  assign accept = bit_ready && bit_valid;

  cfgl_bit_shifter #(.STEP_DIV(STEP_DIV)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .bit_in(bit_data),
    .pin_clk(cfg_clk), .pin_din(cfg_din),
    .active(sh_active), .finish(sh_finish)
  );

  always_comb begin
    ph_nxt  = ph;
    res_nxt = result;
    case (ph)
      PH_IDLE: begin
        if (start) begin
          ph_nxt  = PH_PROG;
          res_nxt = RES_OK;
        end
      end
      PH_PROG: begin
        if (poll) begin
          if (!init_s) begin
            ph_nxt = PH_INITWAIT;
          end else if (last_poll) begin
            ph_nxt  = PH_IDLE;
            res_nxt = RES_INIT_LOW_TO;
          end
        end
      end
      PH_INITWAIT: begin
        if (poll) begin
          if (init_s) begin
            ph_nxt = PH_FETCH;
          end else if (last_poll) begin
            ph_nxt  = PH_IDLE;
            res_nxt = RES_INIT_HIGH_TO;
          end
        end
      end
      PH_FETCH: begin
        if (accept) ph_nxt = PH_SHIFT;
      end
      PH_SHIFT: begin
        if (sh_finish) ph_nxt = last_q ? PH_DONEWAIT : PH_FETCH;
      end
      PH_DONEWAIT: begin
        if (poll) begin
          if (done_s) begin
            ph_nxt  = PH_IDLE;
            res_nxt = RES_OK;
          end else if (last_poll) begin
            ph_nxt  = PH_IDLE;
            res_nxt = RES_DONE_TO;
          end
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      result    <= RES_OK;
      busy      <= 1'b0;
      bit_ready <= 1'b0;
      cfg_prog  <= PROG_OFF;
      last_q    <= 1'b0;
    end else begin
      ph        <= ph_nxt;
      result    <= res_nxt;
      busy      <= (ph_nxt != PH_IDLE);
      bit_ready <= (ph_nxt == PH_FETCH);
      cfg_prog  <= (ph_nxt == PH_PROG) ? PROG_ON : PROG_OFF;
      if (accept) last_q <= bit_last;
    end
  end

  // shifter activity is only expected in the shift phase
  logic unused_ok;
  assign unused_ok = sh_active;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int PROG_ACTIVE_HIGH = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [1:0] result,
  input logic       start,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic       cfg_prog,
  input logic       cfg_clk,
  input logic       cfg_din
);
  localparam logic ACT = (PROG_ACTIVE_HIGH != 0);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cfg_clk && cfg_din && (cfg_prog != ACT) && !bit_ready));

  assert_prog_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_prog == ACT) |-> busy);

  assert_error_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (result != 2'd0) |-> !busy);

  assert_result_steady_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(result));

  assert_result_steady_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(result));

  assert_ready_context_R5: assert property (@(posedge clk) disable iff (rst)
    bit_ready |-> (busy && (cfg_prog != ACT)));

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_ready && bit_valid) |=> !bit_ready);

  assert_din_falls_low_clk_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_din) |-> !cfg_clk);

  assert_din_stable_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_clk) |-> $stable(cfg_din));
endmodule

bind cfg_serial_loader cfgl_checker #(.PROG_ACTIVE_HIGH(PROG_ACTIVE_HIGH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .result(result), .start(start),
  .bit_valid(bit_valid), .bit_ready(bit_ready), .cfg_prog(cfg_prog),
  .cfg_clk(cfg_clk), .cfg_din(cfg_din)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int STEP  = 3;
  localparam int TICK  = 20;
  localparam int POLLS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0, bit_last = 1'b0;
  logic       cfg_init = 1'b1, cfg_done = 1'b0;
  logic       busy, bit_ready, cfg_prog, cfg_clk, cfg_din;
  logic [1:0] result;
  logic       ah_busy, ah_ready, ah_prog, ah_clk, ah_din;
  logic [1:0] ah_result;

  cfg_serial_loader #(.PROG_ACTIVE_HIGH(0), .STEP_DIV(STEP), .TICK_DIV(TICK),
                      .POLL_LIMIT(POLLS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .result(result),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last),
    .bit_ready(bit_ready), .cfg_prog(cfg_prog), .cfg_clk(cfg_clk),
    .cfg_din(cfg_din), .cfg_init(cfg_init), .cfg_done(cfg_done));

  cfg_serial_loader #(.PROG_ACTIVE_HIGH(1), .STEP_DIV(STEP), .TICK_DIV(TICK),
                      .POLL_LIMIT(POLLS), .SYNC_STAGES(2)) uut_ah (
    .clk(clk), .rst(rst), .start(start), .busy(ah_busy), .result(ah_result),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last),
    .bit_ready(ah_ready), .cfg_prog(ah_prog), .cfg_clk(ah_clk),
    .cfg_din(ah_din), .cfg_init(cfg_init), .cfg_done(cfg_done));

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input bit hold_hi, input bit hold_lo, input bit no_done);
    if (hold_hi) return 1;
    if (hold_lo) return 2;
    if (no_done) return 3;
    return 0;
  endfunction

  // target model, evaluated on the falling edge
  bit stuck_hi = 0, stuck_lo = 0, done_never = 0;
  bit exp_bits [64];
  int exp_n = 0, cap_n = 0, low_cnt = 0, rel_cnt = 0;
  bit prev_clk = 1, fall_din = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!cfg_prog) begin
        cfg_init = stuck_hi ? 1'b1 : 1'b0;
        cfg_done = 1'b0;
        cap_n = 0;
        rel_cnt = 0;
      end else if (!cfg_init && !stuck_lo) begin
        rel_cnt++;
        if (rel_cnt >= 6) cfg_init = 1'b1;
      end
      if (!cfg_clk && prev_clk) begin
        fall_din = cfg_din;
        low_cnt = 1;
      end else if (!cfg_clk) begin
        low_cnt++;
      end
      if (cfg_clk && !prev_clk && cap_n < 64) begin
        check(low_cnt == 2 * STEP, "R6 clock low time", low_cnt, 2 * STEP);
        check(fall_din == 1'b1, "R6 data high at clock fall", fall_din, 1);
        check(cfg_din == exp_bits[cap_n], "R7 bit order/value", cfg_din, exp_bits[cap_n]);
        cap_n++;
      end
      if (exp_n > 0 && cap_n == exp_n && !done_never && busy) cfg_done = 1'b1;
      prev_clk = cfg_clk;
    end
  end

  task automatic run_case(input int nbits, input bit hh, input bit hl, input bit nd,
                          output int res, output int cyc, output bit lo_rel);
    int idx = 0;
    bit pend = 0;
    stuck_hi = hh; stuck_lo = hl; done_never = nd;
    exp_n = nbits;
    for (int i = 0; i < nbits; i++) exp_bits[i] = 1'($urandom);
    lo_rel = 0;
    @(negedge clk);
    start = 1'b1;
    cyc = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(cfg_prog == 1'b0, "R2 program active", cfg_prog, 0);
    check(result == 2'd0, "R2 result cleared", result, 0);
    check(ah_prog == 1'b1, "R9 active-high program", ah_prog, 1);
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == 30);
      if (pend) idx++;
      bit_valid = (idx < nbits) && ($urandom % 4 != 0);
      bit_data  = (idx < nbits) ? exp_bits[idx] : 1'b0;
      bit_last  = (idx == nbits - 1);
      pend = bit_valid && bit_ready;
      if (busy && !cfg_init && cfg_prog) lo_rel = 1;
    end
    start = 1'b0;
    bit_valid = 1'b0;
    res = result;
  endtask

  initial begin
    int res, cyc;
    bit lo_rel;
    void'($urandom(32'h5EED_0C0F));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(result == 2'd0, "R1 reset result", result, 0);
    check(cfg_prog == 1'b1, "R1 reset program inactive", cfg_prog, 1);
    check(cfg_clk && cfg_din, "R1 reset clk/din", {cfg_clk, cfg_din}, 3);
    check(bit_ready == 1'b0, "R1 reset ready", bit_ready, 0);
    check(ah_prog == 1'b0, "R9 reset active-high program", ah_prog, 0);

    // directed: normal 8-bit load, with a stray start mid-run
    run_case(8, 0, 0, 0, res, cyc, lo_rel);
    check(res == expect_code(0, 0, 0), "R8 success code", res, 0);
    check(cap_n == 8, "R2 stray start ignored / R5 bit count", cap_n, 8);
    @(negedge clk);
    check(cfg_clk && cfg_din && cfg_prog, "R1 idle pins after load", {cfg_prog, cfg_clk, cfg_din}, 7);

    // directed: single bit that is also the last one
    run_case(1, 0, 0, 0, res, cyc, lo_rel);
    check(res == 0, "R5 single final bit", res, 0);
    check(cap_n == 1, "R5 single bit emitted", cap_n, 1);

    // init never falls
    run_case(4, 1, 0, 0, res, cyc, lo_rel);
    check(res == expect_code(1, 0, 0), "R3 init-low timeout code", res, 1);
    check(cyc >= (POLLS - 1) * TICK && cyc <= (POLLS - 1) * TICK + 4,
          "R3 timeout latency", cyc, (POLLS - 1) * TICK + 2);
    check(cap_n == 0, "R3 no bits after timeout", cap_n, 0);

    // init never returns high
    run_case(4, 0, 1, 0, res, cyc, lo_rel);
    check(res == expect_code(0, 1, 0), "R4 init-high timeout code", res, 2);
    check(lo_rel == 1'b1, "R4 program released while init low", lo_rel, 1);

    // done never rises
    run_case(12, 0, 0, 1, res, cyc, lo_rel);
    check(res == expect_code(0, 0, 1), "R8 done timeout code", res, 3);
    check(cap_n == 12, "R8 all bits sent before done wait", cap_n, 12);
    repeat (50) @(negedge clk);
    check(result == 2'd3, "R10 error code held while idle", result, 3);
    check(busy == 1'b0, "R10 idle after error", busy, 0);

    // random successful loads
    for (int k = 0; k < 6; k++) begin
      int n = 1 + int'($urandom % 40);
      run_case(n, 0, 0, 0, res, cyc, lo_rel);
      check(res == 0, "R8 random load result", res, 0);
      check(cap_n == n, "R7 random load bit count", cap_n, n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule